// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides its input clock by a programmable integer N and emits one single-cycle pulse per N input cycles. It is the feedback divider of an integer-N synthesizer loop. A dual-modulus prescaler divides by P or P+1. A swallow counter selects the higher modulus for the first A prescaler cycles of each output period. A main counter ends the period after B prescaler cycles in total. The division ratio is therefore N = P·B + A. All three parts are written as synchronous logic clocked by the input clock.

The prescaler mode, A and B are presented on staging inputs. They have no effect until a load request is given. The request is held in a pending flag, and the staged setting is copied into the active divider at the end of the output period that is running. This keeps every emitted period whole. A staged setting that breaks the range rules is refused at that moment: the previous active setting stays, and an error flag is raised.

Top module: `pswallow_div`

## Requirements
- R1: The 2-bit mode code sets the prescaler base modulus P. Code 00 gives P=8, 01 gives 16, 10 gives 32 and 11 gives 64.
- R2: With an active setting (P, A, B), `div_pulse_o` is high for exactly one input cycle out of every N = P·B + A input cycles.
- R3: Legal settings have A in 0..63 and B in 3..8191 with B ≥ A. The boundary cases B = A and B = 3 are accepted.
- R4: A high `load_req_i` sampled at a clock edge sets `load_pend_o` at that edge. Changing the staging inputs without a load request leaves the output period unchanged.
- R5: A pending request is applied at the edge that ends the current output period, and `load_pend_o` clears at that same edge. The next full period uses the new N.
- R6: An applied setting with B < 3 or A > B sets `cfg_err_o` and leaves the previous N in force. An applied legal setting clears `cfg_err_o`.
- R7: While `rst_ni` is low, the outputs `div_pulse_o`, `load_pend_o` and `cfg_err_o` are 0. Reset also restores mode 00, A = 0 and B = 3, so N = 24. After release, the first pulse appears in the 24th input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stage_mode_i | input | 2 | Staged prescaler mode code |
| stage_swallow_i | input | 6 | Staged swallow count A |
| stage_main_i | input | 13 | Staged main count B |
| load_req_i | input | 1 | Request to load the staged setting |
| load_pend_o | output | 1 | Load request waiting for the period end |
| div_pulse_o | output | 1 | One-cycle pulse that ends each period |
| cfg_err_o | output | 1 | Last applied setting was refused |

## Verification
The bench measures every interval between output pulses against P·B + A. It does this over all four modes, with no swallow, with the maximum swallow of 63 at B = A, and with a large B. A design that loses track of the swallow phase would give P·B or (P+1)·B. A design that applies a request at once, instead of at the period end, would produce one interval of neither the old nor the new length. The bench also loads settings with B = 2 and with A > B. An implementation that checks the wrong bound would change N there or leave the error flag low. A mid-run reset has to restart at N = 24, with the first pulse on the 24th cycle.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  typedef enum logic [1:0] {
    PSC_8  = 2'b00,
    PSC_16 = 2'b01,
    PSC_32 = 2'b10,
    PSC_64 = 2'b11
  } psc_mode_e;

  localparam int unsigned PSC_CNT_W = 7;

  // Base modulus P for a mode code; the high modulus is P+1.
  function automatic logic [PSC_CNT_W-1:0] base_modulus(input psc_mode_e mode);
    logic [PSC_CNT_W-1:0] m;
    m = 7'd8 << mode;
    return m;
  endfunction

endpackage

// File: rtl/pswallow_cfg.sv
module pswallow_cfg
  import pswallow_pkg::*;
#(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 13,
  parameter int unsigned B_MIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     stage_mode_i,
  input  logic [A_W-1:0] stage_a_i,
  input  logic [B_W-1:0] stage_b_i,
  input  logic           load_req_i,
  input  logic           period_end_i,
  output psc_mode_e      nxt_mode_o,
  output logic [A_W-1:0] nxt_a_o,
  output logic [B_W-1:0] nxt_b_o,
  output psc_mode_e      act_mode_o,
  output logic [A_W-1:0] act_a_o,
  output logic [B_W-1:0] act_b_o,
  output logic           pend_o,
  output logic           err_o
);

  localparam logic [B_W-1:0] BMIN_V = B_W'(B_MIN);

  psc_mode_e      act_mode_q;
  logic [A_W-1:0] act_a_q;
  logic [B_W-1:0] act_b_q;
  logic           pend_q, pend_d;
  logic           err_q, err_d;
  logic           apply, legal, take;

  always_comb begin
    legal  = (stage_b_i >= BMIN_V) && (B_W'(stage_a_i) <= stage_b_i);
    apply  = period_end_i && pend_q;
    take   = apply && legal;
    pend_d = apply ? 1'b0 : (pend_q | load_req_i);
    err_d  = apply ? !legal : err_q;
    nxt_mode_o = take ? psc_mode_e'(stage_mode_i) : act_mode_q;
    nxt_a_o    = take ? stage_a_i : act_a_q;
    nxt_b_o    = take ? stage_b_i : act_b_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_mode_q <= PSC_8;
      act_a_q    <= '0;
      act_b_q    <= BMIN_V;
      pend_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
      if (take) begin
        act_mode_q <= nxt_mode_o;
        act_a_q    <= nxt_a_o;
        act_b_q    <= nxt_b_o;
      end
    end
  end

  assign act_mode_o = act_mode_q;
  assign act_a_o    = act_a_q;
  assign act_b_o    = act_b_q;
  assign pend_o     = pend_q;
  assign err_o      = err_q;

endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  psc_mode_e mode_i,
  input  logic      high_mod_i,
  output logic      tick_o
);

  logic [PSC_CNT_W-1:0] cnt_q, cnt_d;
  logic [PSC_CNT_W-1:0] last;

  always_comb begin
    last   = base_modulus(mode_i) - (high_mod_i ? 7'd0 : 7'd1);
    tick_o = (cnt_q == last);
    cnt_d  = tick_o ? '0 : cnt_q + 7'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters #(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 13,
  parameter int unsigned B_MIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [A_W-1:0] nxt_a_i,
  input  logic [B_W-1:0] nxt_b_i,
  output logic           high_mod_o,
  output logic           period_end_o
);

  logic [A_W-1:0] swl_q, swl_d;
  logic [B_W-1:0] main_q, main_d;

  always_comb begin
    high_mod_o   = (swl_q != '0);
    period_end_o = tick_i && (main_q == '0);
    swl_d  = swl_q;
    main_d = main_q;
    if (period_end_o) begin
      swl_d  = nxt_a_i;
      main_d = nxt_b_i - B_W'(1);
    end else if (tick_i) begin
      main_d = main_q - B_W'(1);
      if (high_mod_o) swl_d = swl_q - A_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swl_q  <= '0;
      main_q <= B_W'(B_MIN - 1);
    end else begin
      swl_q  <= swl_d;
      main_q <= main_d;
    end
  end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 13,
  parameter int unsigned B_MIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     stage_mode_i,
  input  logic [A_W-1:0] stage_swallow_i,
  input  logic [B_W-1:0] stage_main_i,
  input  logic           load_req_i,
  output logic           load_pend_o,
  output logic           div_pulse_o,
  output logic           cfg_err_o
);

  psc_mode_e      nxt_mode, act_mode;
  logic [A_W-1:0] nxt_a, act_a;
  logic [B_W-1:0] nxt_b, act_b;
  logic           tick, high_mod, period_end;

  pswallow_cfg #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stage_mode_i (stage_mode_i),
    .stage_a_i    (stage_swallow_i),
    .stage_b_i    (stage_main_i),
    .load_req_i   (load_req_i),
    .period_end_i (period_end),
    .nxt_mode_o   (nxt_mode),
    .nxt_a_o      (nxt_a),
    .nxt_b_o      (nxt_b),
    .act_mode_o   (act_mode),
    .act_a_o      (act_a),
    .act_b_o      (act_b),
    .pend_o       (load_pend_o),
    .err_o        (cfg_err_o)
  );

  pswallow_prescaler u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (act_mode),
    .high_mod_i (high_mod),
    .tick_o     (tick)
  );

  pswallow_counters #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .nxt_a_i      (nxt_a),
    .nxt_b_i      (nxt_b),
    .high_mod_o   (high_mod),
    .period_end_o (period_end)
  );

  assign div_pulse_o = period_end;

endmodule

// File: rtl/pswallow_chk.sv
module pswallow_chk #(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 13,
  parameter int unsigned B_MIN = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           load_req_i,
  input logic           load_pend_o,
  input logic           div_pulse_o,
  input logic           cfg_err_o,
  input logic [A_W-1:0] act_a,
  input logic [B_W-1:0] act_b
);

  // R2: a pulse lasts one cycle (N is at least 24)
  assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);

  // R4: a request raises the pending flag
  assert_req_sets_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req_i |=> load_pend_o);

  // R5: pending only clears at a period end
  assert_pend_clear_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_pend_o) |-> $past(div_pulse_o));

  // R6: error flag only moves when a pending load is applied
  assert_err_moves_on_apply_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_err_o) |-> $past(div_pulse_o && load_pend_o));

  // R3: active setting always within the legal ranges
  assert_active_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_b >= B_W'(B_MIN)) && (B_W'(act_a) <= act_b));

endmodule

bind pswallow_div pswallow_chk #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_req_i  (load_req_i),
  .load_pend_o (load_pend_o),
  .div_pulse_o (div_pulse_o),
  .cfg_err_o   (cfg_err_o),
  .act_a       (act_a),
  .act_b       (act_b)
);

// File: tb/sim_pswallow_div.sv
module sim_pswallow_div;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  st_mode = 2'b00;
  logic [5:0]  st_a = '0;
  logic [12:0] st_b = 13'd3;
  logic        ld = 1'b0;
  logic        pend, pulse, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { int n; bit e; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pswallow_div u0 (
    .clk_i(clk), .rst_ni(rst_n), .stage_mode_i(st_mode),
    .stage_swallow_i(st_a), .stage_main_i(st_b), .load_req_i(ld),
    .load_pend_o(pend), .div_pulse_o(pulse), .cfg_err_o(err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench model of the divider: N from mode, A, B (R1, R2)
  int model_n = 24;
  bit model_e = 1'b0;

  // Monitor: interval between pulses against the expected N
  int cnt = 0;
  int cur_n = 24;
  bit exp_err = 1'b0;
  bit chk_err = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0;
      cur_n = 24;
      chk_err = 1'b0;
      q.delete();
    end else begin
      cnt++;
      if (chk_err) begin
        check("R6 error flag", int'(err), int'(exp_err));
        chk_err = 1'b0;
      end
      if (pulse) begin
        check("R2/R5 period length", cnt, cur_n);
        cnt = 0;
        if (pend && q.size() > 0) begin
          exp_t it;
          it = q.pop_front();
          cur_n = it.n;
          exp_err = it.e;
          chk_err = 1'b1;
        end
      end
    end
  end

  task automatic wait_pulses(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      while (!pulse) @(negedge clk);
    end
  endtask

  task automatic do_load(input logic [1:0] m, input int a, input int b);
    exp_t it;
    int p;
    @(posedge clk); #1;
    st_mode = m; st_a = a[5:0]; st_b = b[12:0];
    p = 8 << m;
    // R3, R6: legal when B >= 3 and A <= B
    if (b >= 3 && a <= b) begin
      model_n = p * b + a;
      model_e = 1'b0;
    end else begin
      model_e = 1'b1;
    end
    it.n = model_n; it.e = model_e;
    q.push_back(it);
    ld = 1'b1;
    @(posedge clk); #1;
    ld = 1'b0;
    @(negedge clk);
    check("R4 pending set", int'(pend), 1);
    while (pend) @(negedge clk);
    wait_pulses(2);
  endtask

  initial begin
    @(negedge clk);
    // R7: outputs low during reset
    check("R7 pulse in reset", int'(pulse), 0);
    check("R7 pending in reset", int'(pend), 0);
    check("R7 error in reset", int'(err), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    wait_pulses(2);                 // R7 default N=24
    do_load(2'b01, 5, 10);          // R1 mode 16: 165
    do_load(2'b11, 63, 63);         // R3 B=A, A max: 4095
    do_load(2'b10, 0, 3);           // R3 B min: 96
    do_load(2'b00, 0, 2);           // R6 B below 3: refused
    do_load(2'b01, 10, 9);          // R6 A>B: refused
    do_load(2'b00, 7, 7);           // R6 cleared: 63
    // R4: staging change without request ignored
    @(posedge clk); #1;
    st_mode = 2'b11; st_a = 6'd1; st_b = 13'd50;
    wait_pulses(3);
    check("R4 no pending without request", int'(pend), 0);
    do_load(2'b00, 63, 2000);       // R2 large B: 16063
    // R7: reset mid-run restarts at default N
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 error cleared by reset", int'(err), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    wait_pulses(2);
    finish_run();
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule